// File: doc/BRIEF.md
# Programmable Sub-Pixel Edge Clock Generator

This block produces the horizontal readout clocks, the reset gate clock and the two correlated-double-sampling strobes for an image sensor front end. Each pixel period is cut into 48 steps. A phase counter runs on a fast reference clock and moves one step per prescaled tick, and every output edge is placed on one of those 48 steps.

The reset gate always rises at step 0, and its falling step is set by a register. The first horizontal clock has a register-set rising step and stays high for half the period, wrapping across the pixel boundary when needed. The second horizontal clock is its complement. The reference sample strobe and the data sample strobe are each one step wide, at their own register-set steps. Each edge is written as a 6-bit code: a 2-bit quadrant picks a 12-step quarter of the period and a 4-bit offset picks a step inside it.

A parallel write port loads shadow registers at any time. The new settings, including the prescaler ratio, only apply from the first step of the following pixel period, so a write never cuts an output pulse short.

Top module: `pix_edge_clkgen`

## Requirements
- R1: The step counter covers 0..47. It advances by one on each prescaled tick and goes from 47 back to 0.
- R2: A divider code d (0..3), written to address 0 in data bits [1:0], gives one step every d+1 reference clocks. After reset d is 0.
- R3: `rg_o` is high from step 0 up to the step before the decoded falling step, and low from the falling step to 47. A falling step of 0 keeps it low for the whole period. The code is at address 1.
- R4: `h1_o` is high for 24 consecutive steps starting at the decoded rising step, counted modulo 48. The code is at address 2.
- R5: `h2_o` is always the inverse of `h1_o`.
- R6: `shp_o` and `shd_o` are each high for exactly one step, the one equal to their decoded step. The codes are at addresses 3 and 4.
- R7: A code's bits [5:4] give a quadrant q, and bits [3:0] give an offset o. The decoded step is 12*q + min(o, 11).
- R8: A write lands in a shadow register at once. The outputs and the step rate use it only from step 0 of the next pixel period.
- R9: Writes to addresses 5, 6 and 7 have no effect on any output.
- R10: After reset the step is 0 and the divider code is 0. The reset gate falls at step 12, the first horizontal clock rises at step 0, the reference strobe sits at step 24 and the data strobe at step 0. The outputs hold rg=1, h1=1, h2=0, shp=0, shd=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 6 | Write data (edge code or divider code) |
| rg_o | output | 1 | Reset gate clock |
| h1_o | output | 1 | First horizontal clock |
| h2_o | output | 1 | Second horizontal clock, inverse of h1_o |
| shp_o | output | 1 | Reference-level sample strobe |
| shd_o | output | 1 | Data-level sample strobe |

## Verification
The hardest case to reach is a pixel boundary where several things change together. At that boundary the divider ratio and the edge positions change at once, so a high window that wraps past step 47 has to be rebuilt with new positions on a new step rate. The stimulus waits for the bench's own start-of-pixel event and writes a complete new configuration in the middle of the period. This includes a new divider code, wrapping rising positions, clamped offsets and writes to unused addresses. The bench then checks every reference cycle across the switch, which covers the last step of the old pixel and step 0 of the new one.

// File: rtl/pix_edge_pkg.sv
package pix_edge_pkg;

   // Register channels; the write address of channel e is e+1, address 0 is the divider
   localparam int unsigned EDGE_CNT = 4;
   localparam int unsigned EDGE_RG  = 0;
   localparam int unsigned EDGE_H1  = 1;
   localparam int unsigned EDGE_SHP = 2;
   localparam int unsigned EDGE_SHD = 3;

   // Quadrant/offset code to step index, offset clamped to the quadrant length
   function automatic int unsigned code_to_step(input int unsigned code,
                                                input int unsigned off_w,
                                                input int unsigned quad_len);
      int unsigned quad;
      int unsigned off;
      quad = code >> off_w;
      off  = code & ((32'd1 << off_w) - 32'd1);
      if (off > quad_len - 1) off = quad_len - 1;
      return quad * quad_len + off;
   endfunction

endpackage

// File: rtl/pix_edge_pos.sv
module pix_edge_pos
   import pix_edge_pkg::*;
#(
   parameter int unsigned CODE_W = 6,
   parameter int unsigned STEPS  = 48,
   parameter int unsigned QUADS  = 4,
   localparam int unsigned PH_W  = $clog2(STEPS)
)(
   input  logic [CODE_W-1:0] code_i,
   output logic [PH_W-1:0]   step_o
);
   localparam int unsigned QUAD_W   = $clog2(QUADS);
   localparam int unsigned OFF_W    = CODE_W - QUAD_W;
   localparam int unsigned QUAD_LEN = STEPS / QUADS;

   assign step_o = PH_W'(code_to_step(32'(code_i), OFF_W, QUAD_LEN));

endmodule

// File: rtl/pix_edge_phase.sv
module pix_edge_phase #(
   parameter int unsigned STEPS   = 48,
   parameter int unsigned MAX_DIV = 4,
   localparam int unsigned PH_W   = $clog2(STEPS),
   localparam int unsigned DIV_W  = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_sel_i,
   output logic             tick_o,
   output logic             wrap_o,
   output logic [PH_W-1:0]  ph_q_o,
   output logic [PH_W-1:0]  ph_nxt_o
);
   localparam logic [PH_W-1:0] LAST = PH_W'(STEPS - 1);

   logic [PH_W-1:0] ph_q;

   generate
      if (MAX_DIV == 1) begin : g_nodiv
         assign tick_o = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      cnt_q <= '0;
            else if (tick_o)  cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == div_sel_i);

         a_r2_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tick_o |=> (!tick_o || div_sel_i == '0));
         a_r2_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !tick_o |=> (cnt_q == $past(cnt_q) + 1'b1));
      end
   endgenerate

   assign wrap_o = tick_o && (ph_q == LAST);

   always_comb begin
      ph_nxt_o = ph_q;
      if (tick_o) ph_nxt_o = (ph_q == LAST) ? '0 : ph_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ph_q <= '0;
      else         ph_q <= ph_nxt_o;
   end

   assign ph_q_o = ph_q;

   a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (ph_q == '0));
   a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && ph_q != LAST) |=> (ph_q == $past(ph_q) + 1'b1));
   a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_o |=> $stable(ph_q));

endmodule

// File: rtl/pix_edge_regs.sv
module pix_edge_regs #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CODE_W = 6,
   parameter int unsigned DIV_W  = 2,
   parameter int unsigned EDGES  = 4,
   parameter logic [EDGES*CODE_W-1:0] RST_CODES = '0,
   parameter logic [DIV_W-1:0]        RST_DIV   = '0
)(
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-1:0]       wr_addr_i,
   input  logic [CODE_W-1:0]       wr_data_i,
   input  logic                    commit_i,
   output logic [DIV_W-1:0]        div_q_o,
   output logic [EDGES*CODE_W-1:0] codes_q_o,
   output logic [EDGES*CODE_W-1:0] codes_nxt_o
);
   logic             div_hit;
   logic [DIV_W-1:0] div_shad_q;
   logic [DIV_W-1:0] div_act_q;

   assign div_hit = wr_en_i && (wr_addr_i == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_shad_q <= RST_DIV;
         div_act_q  <= RST_DIV;
      end else begin
         if (div_hit)  div_shad_q <= wr_data_i[DIV_W-1:0];
         if (commit_i) div_act_q  <= div_shad_q;
      end
   end

   assign div_q_o = div_act_q;

   generate
      for (genvar e = 0; e < EDGES; e++) begin : g_edge
         localparam logic [CODE_W-1:0] RST = RST_CODES[e*CODE_W +: CODE_W];
         logic              hit;
         logic [CODE_W-1:0] shad_q;
         logic [CODE_W-1:0] act_q;

         assign hit = wr_en_i && (wr_addr_i == ADDR_W'(e + 1));

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               shad_q <= RST;
               act_q  <= RST;
            end else begin
               if (hit)      shad_q <= wr_data_i;
               if (commit_i) act_q  <= shad_q;
            end
         end

         assign codes_q_o[e*CODE_W +: CODE_W]   = act_q;
         assign codes_nxt_o[e*CODE_W +: CODE_W] = commit_i ? shad_q : act_q;
      end
   endgenerate

   a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> ($stable(codes_q_o) && $stable(div_q_o)));

endmodule

// File: rtl/pix_edge_clkgen.sv
module pix_edge_clkgen
   import pix_edge_pkg::*;
#(
   parameter int unsigned STEPS   = 48,
   parameter int unsigned QUADS   = 4,
   parameter int unsigned CODE_W  = 6,
   parameter int unsigned MAX_DIV = 4,
   parameter int unsigned ADDR_W  = 3,
   parameter logic [CODE_W-1:0] RG_FALL_RST = 6'h10,
   parameter logic [CODE_W-1:0] H1_RISE_RST = 6'h00,
   parameter logic [CODE_W-1:0] SHP_RST     = 6'h20,
   parameter logic [CODE_W-1:0] SHD_RST     = 6'h00
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CODE_W-1:0] wr_data_i,
   output logic              rg_o,
   output logic              h1_o,
   output logic              h2_o,
   output logic              shp_o,
   output logic              shd_o
);
   localparam int unsigned PH_W     = $clog2(STEPS);
   localparam int unsigned DIV_W    = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
   localparam int unsigned QUAD_LEN = STEPS / QUADS;
   localparam int unsigned QUAD_W   = $clog2(QUADS);
   localparam int unsigned OFF_W    = CODE_W - QUAD_W;
   localparam int unsigned HALF     = STEPS / 2;
   localparam int unsigned EDGES    = EDGE_CNT;
   localparam logic [EDGES*CODE_W-1:0] RST_CODES = {SHD_RST, SHP_RST, H1_RISE_RST, RG_FALL_RST};

   // Elaboration-time parameter checks
   generate
      if (STEPS % QUADS != 0) begin : g_chk_quads
         $error("pix_edge_clkgen: STEPS must split evenly into QUADS");
      end
      if ((1 << OFF_W) < QUAD_LEN) begin : g_chk_off
         $error("pix_edge_clkgen: offset field too narrow for a quadrant");
      end
      if (STEPS % 2 != 0) begin : g_chk_half
         $error("pix_edge_clkgen: STEPS must be even");
      end
      if ((1 << ADDR_W) < EDGES + 1) begin : g_chk_addr
         $error("pix_edge_clkgen: address space too small");
      end
      if (CODE_W < DIV_W || MAX_DIV < 1) begin : g_chk_div
         $error("pix_edge_clkgen: bad divider configuration");
      end
   endgenerate

   // Output shaping, shared by the reset values and the running logic
   function automatic logic [PH_W-1:0] since_rise(input logic [PH_W-1:0] ph,
                                                  input logic [PH_W-1:0] rise);
      if (ph >= rise) return ph - rise;
      return PH_W'(32'(ph) + STEPS - 32'(rise));
   endfunction

   function automatic logic rg_level(input logic [PH_W-1:0] ph, input logic [PH_W-1:0] fall);
      return ph < fall;
   endfunction

   logic             tick;
   logic             wrap;
   logic [PH_W-1:0]  ph_q;
   logic [PH_W-1:0]  ph_nxt;
   logic [DIV_W-1:0] div_q;
   logic [EDGES*CODE_W-1:0] codes_q;
   logic [EDGES*CODE_W-1:0] codes_nxt;
   logic [PH_W-1:0]  pos_q   [EDGES];
   logic [PH_W-1:0]  pos_nxt [EDGES];
   logic [PH_W-1:0]  h1_age_nxt;

   pix_edge_regs #(
      .ADDR_W    (ADDR_W),
      .CODE_W    (CODE_W),
      .DIV_W     (DIV_W),
      .EDGES     (EDGES),
      .RST_CODES (RST_CODES),
      .RST_DIV   ('0)
   ) regs_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .commit_i    (wrap),
      .div_q_o     (div_q),
      .codes_q_o   (codes_q),
      .codes_nxt_o (codes_nxt)
   );

   pix_edge_phase #(
      .STEPS   (STEPS),
      .MAX_DIV (MAX_DIV)
   ) phase_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_sel_i (div_q),
      .tick_o    (tick),
      .wrap_o    (wrap),
      .ph_q_o    (ph_q),
      .ph_nxt_o  (ph_nxt)
   );

   generate
      for (genvar e = 0; e < EDGES; e++) begin : g_dec
         pix_edge_pos #(.CODE_W(CODE_W), .STEPS(STEPS), .QUADS(QUADS)) nxt_i (
            .code_i (codes_nxt[e*CODE_W +: CODE_W]),
            .step_o (pos_nxt[e])
         );
         pix_edge_pos #(.CODE_W(CODE_W), .STEPS(STEPS), .QUADS(QUADS)) cur_i (
            .code_i (codes_q[e*CODE_W +: CODE_W]),
            .step_o (pos_q[e])
         );
      end
   endgenerate

   localparam logic [PH_W-1:0] RG_RST_POS  = PH_W'(code_to_step(32'(RG_FALL_RST), OFF_W, QUAD_LEN));
   localparam logic [PH_W-1:0] H1_RST_POS  = PH_W'(code_to_step(32'(H1_RISE_RST), OFF_W, QUAD_LEN));
   localparam logic [PH_W-1:0] SHP_RST_POS = PH_W'(code_to_step(32'(SHP_RST), OFF_W, QUAD_LEN));
   localparam logic [PH_W-1:0] SHD_RST_POS = PH_W'(code_to_step(32'(SHD_RST), OFF_W, QUAD_LEN));

   assign h1_age_nxt = since_rise(ph_nxt, pos_nxt[EDGE_H1]);

   // Outputs are registered on the tick that enters the step they describe
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rg_o  <= rg_level('0, RG_RST_POS);
         h1_o  <= (32'(since_rise('0, H1_RST_POS)) <  HALF);
         h2_o  <= (32'(since_rise('0, H1_RST_POS)) >= HALF);
         shp_o <= (SHP_RST_POS == '0);
         shd_o <= (SHD_RST_POS == '0);
      end else if (tick) begin
         rg_o  <= rg_level(ph_nxt, pos_nxt[EDGE_RG]);
         h1_o  <= (32'(h1_age_nxt) <  HALF);
         h2_o  <= (32'(h1_age_nxt) >= HALF);
         shp_o <= (ph_nxt == pos_nxt[EDGE_SHP]);
         shd_o <= (ph_nxt == pos_nxt[EDGE_SHD]);
      end
   end

   localparam logic [PH_W-1:0] HALF_P = PH_W'(HALF);
   logic [PH_W-1:0] h1_fall_q;
   assign h1_fall_q = (32'(pos_q[EDGE_H1]) + HALF >= STEPS) ?
                      pos_q[EDGE_H1] - HALF_P : pos_q[EDGE_H1] + HALF_P;

   a_r3_rg_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rg_o) |-> (ph_q == '0));
   a_r3_rg_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rg_o) |-> (ph_q == pos_q[EDGE_RG]));
   a_r4_h1_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(h1_o) && !$past(wrap)) |-> (ph_q == pos_q[EDGE_H1]));
   a_r4_h1_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(h1_o) && !$past(wrap)) |-> (ph_q == h1_fall_q));
   a_r5_h2_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      h2_o != h1_o);
   a_r6_shp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shp_o == (ph_q == pos_q[EDGE_SHP]));
   a_r6_shd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shd_o == (ph_q == pos_q[EDGE_SHD]));

endmodule

// File: tb/pix_edge_clkgen_tb_top.sv
module pix_edge_clkgen_tb_top;
   localparam int STEPS = 48;
   localparam int WATCHDOG = 200000;

   typedef struct {
      int divf;
      int rg;
      int h1;
      int shp;
      int shd;
   } cfg_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       wr_en;
   logic [2:0] wr_addr;
   logic [5:0] wr_data;
   logic       rg, h1, h2, shp, shd;

   always #5 clk = ~clk;

   pix_edge_clkgen dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rg_o      (rg),
      .h1_o      (h1),
      .h2_o      (h2),
      .shp_o     (shp),
      .shd_o     (shd)
   );

   int   total = 0;
   int   bad   = 0;
   bit   done  = 0;
   bit   past_reset_cfg = 0;
   cfg_t exp_q[$];
   cfg_t m_act = '{1, 12, 0, 24, 0};
   int   m_cnt = 0;
   int   m_ph  = 0;
   event pix_ev;

   // R7: step = 12*q + min(offset, 11)
   function automatic int decode(input logic [5:0] c);
      int q, o;
      q = int'(c[5:4]);
      o = int'(c[3:0]);
      if (o > 11) o = 11;
      return q * 12 + o;
   endfunction

   task automatic check(input string tag, input string name, input logic got, input logic want);
      total++;
      if (got !== want) begin
         bad++;
         $display("FAIL %s %s (step R1, divider R2): got %0b expected %0b at step %0d div %0d",
                  tag, name, got, want, m_ph, m_act.divf);
      end
   endtask

   // Monitor: own step model, pops the queued configuration at each pixel start
   initial begin
      forever begin
         logic r;
         bit   want_h1;
         @(posedge clk);
         r = rst_n;
         @(negedge clk);
         if (r) begin
            if (m_cnt == m_act.divf - 1) begin
               m_cnt = 0;
               if (m_ph == STEPS - 1) begin
                  m_ph = 0;
                  past_reset_cfg = 1;
                  if (exp_q.size() > 0) m_act = exp_q.pop_front();
                  -> pix_ev;
               end else begin
                  m_ph++;
               end
            end else begin
               m_cnt++;
            end
         end
         want_h1 = (((m_ph - m_act.h1 + STEPS) % STEPS) < STEPS / 2);
         if (!past_reset_cfg) begin
            check("R10", "rg",  rg,  m_ph < m_act.rg);
            check("R10", "h1",  h1,  want_h1);
            check("R10", "h2",  h2,  !want_h1);
            check("R10", "shp", shp, m_ph == m_act.shp);
            check("R10", "shd", shd, m_ph == m_act.shd);
         end else begin
            check("R3", "rg",  rg,  m_ph < m_act.rg);
            check("R4", "h1",  h1,  want_h1);
            check("R5", "h2",  h2,  !want_h1);
            check("R6", "shp", shp, m_ph == m_act.shp);
            check("R6", "shd", shd, m_ph == m_act.shd);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [5:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Driver: writes mid-pixel (R8), queues the expected configuration for the next pixel
   task automatic program_pixel(input int divf, input logic [5:0] rgc, input logic [5:0] h1c,
                                input logic [5:0] shpc, input logic [5:0] shdc, input bit junk);
      cfg_t c;
      @(pix_ev);
      @(negedge clk);
      wr(3'd0, 6'(divf - 1));
      wr(3'd1, rgc);
      wr(3'd2, h1c);
      wr(3'd3, shpc);
      wr(3'd4, shdc);
      if (junk) begin
         // R9: unused addresses must leave every output untouched
         wr(3'd5, 6'h3F);
         wr(3'd6, 6'h15);
         wr(3'd7, 6'h2A);
      end
      c.divf = divf;
      c.rg   = decode(rgc);
      c.h1   = decode(h1c);
      c.shp  = decode(shpc);
      c.shd  = decode(shdc);
      exp_q.push_back(c);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got no finish expected finish within %0d cycles", WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      #1 rst_n = 1'b0;               // R10 reset state checked while held and in the first pixel
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      program_pixel(1, 6'h05, 6'h03, 6'h21, 6'h07, 1'b0);   // R2 div 1, plain positions
      program_pixel(2, 6'h3B, 6'h2A, 6'h1F, 6'h3F, 1'b0);   // R7 clamps, R4 fall wraps to 10
      program_pixel(3, 6'h00, 6'h30, 6'h00, 6'h11, 1'b1);   // R3 rg never high, R9 junk
      program_pixel(4, 6'h1C, 6'h0B, 6'h2C, 6'h34, 1'b1);   // R2 div 4, R7 clamps
      program_pixel(1, 6'h30, 6'h2F, 6'h3B, 6'h01, 1'b0);   // R8 rate and edges switch together
      program_pixel(2, 6'h2F, 6'h3F, 6'h0C, 6'h2B, 1'b1);   // R1 wrap with late edges
      @(pix_ev);
      @(pix_ev);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule